// File: doc/BRIEF.md
# Load-Adaptive PWM Frequency Scheduler

This block sets the timing of the gate pulses for a peak-current-mode switching converter. A 10-bit digitized feedback code stands for the load. From that code the block picks the switching period. At heavy load the period is fixed at the short value, with a slow triangular dither added. In the medium band the period stretches linearly toward the long value. Below that band the period stays clamped at the long value. At very light load, switching stops altogether (burst), and it restarts at a slightly higher level than the one that stopped it.

Each cycle begins with a one-clock start strobe, and the gate rises in that same clock. The gate ends at the earliest of three points: a current-sense comparator trip, the duty-cycle cap, or the end of the period. The period and duty cap are computed from the feedback code once per cycle, at the cycle boundary. A change of load during a cycle therefore never shortens or stretches the pulse already in progress. The feedback code and the comparator input are plain level inputs, sampled on every clock. There is no handshake, and nothing is held back.

Top module: `pwm_freq_sched`

## Requirements
- R1: While reset is asserted and after its release until the first cycle starts, `gate_on`, `cycle_start` and `burst_active` are low.
- R2: When the feedback code sampled at a cycle boundary is at or above `KNEE_CODE`, the cycle lasts `PERIOD_FAST` plus the current dither offset clocks.
- R3: For a code strictly between `FLOOR_CODE` and `KNEE_CODE`, the cycle lasts `PERIOD_FAST + ((KNEE_CODE-code)*(PERIOD_SLOW-PERIOD_FAST))/(KNEE_CODE-FLOOR_CODE)` clocks (integer division).
- R4: For a code at or below `FLOOR_CODE` (and not in burst), the cycle lasts `PERIOD_SLOW` clocks.
- R5: A code below `STOP_CODE` sets `burst_active` one clock later. From the clock after that, the gate stays low and no cycle starts.
- R6: While in burst, codes from `STOP_CODE` up to `RESUME_CODE` keep `burst_active` set. A code above `RESUME_CODE` clears it one clock later, and switching then resumes with a new cycle.
- R7: Within a cycle, the gate is high for at most `(period*DUTY_PCT)/100` clocks, counted from the start strobe.
- R8: If `cs_trip` is high at a clock edge while the gate is high, the gate is low after that edge and stays low for the rest of the cycle.
- R9: The period and duty cap are taken from the code present at the boundary clock only. A code change in mid-cycle affects the next cycle, not the current one.
- R10: The dither offset starts at 0 and moves by one at each cycle start, rising to +`HOP_AMP`, then falling to -`HOP_AMP`, and so on as a triangle. It is applied only in the fixed region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_code | input | FB_W | Digitized feedback (load) level |
| cs_trip | input | 1 | Current-sense comparator, high ends the pulse |
| gate_on | output | 1 | Gate drive enable |
| cycle_start | output | 1 | One-clock strobe at each cycle start |
| burst_active | output | 1 | Switching suspended by light load |

## Verification
The bench builds the block with `PERIOD_FAST` = 40, `PERIOD_SLOW` = 100 and `HOP_AMP` = 3, and keeps the default feedback thresholds. With these short periods, many dither turns, the linear band, the floor and burst entry and exit all fit in a short run. The reduced dither amplitude lets the triangle reverse several times, so both reversal points are observed. With the 85 % cap on short periods, rounding produces visibly odd cap values such as 59 of 70.

// File: rtl/pwm_sched_pkg.sv
package pwm_sched_pkg;
  typedef enum logic {
    HOP_RISE = 1'b0,
    HOP_FALL = 1'b1
  } hop_dir_e;
endpackage

// File: rtl/pwm_burst_gate.sv
module pwm_burst_gate #(
  parameter int FB_W        = 10,
  parameter int STOP_CODE   = 410,
  parameter int RESUME_CODE = 430
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_code,
  output logic            burst
);
  localparam logic [FB_W-1:0] STOP_C   = FB_W'(STOP_CODE);
  localparam logic [FB_W-1:0] RESUME_C = FB_W'(RESUME_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst <= 1'b0;
    end else if (burst) begin
      if (fb_code > RESUME_C) burst <= 1'b0;
    end else if (fb_code < STOP_C) begin
      burst <= 1'b1;
    end
  end
endmodule

// File: rtl/pwm_hop_gen.sv
module pwm_hop_gen
  import pwm_sched_pkg::*;
#(
  parameter int HOP_AMP = 20,
  parameter int HOP_W   = $clog2(HOP_AMP + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  output logic signed [HOP_W-1:0] offset
);
  generate
    if (HOP_AMP == 0) begin : g_flat
      assign offset = '0;
    end else begin : g_tri
      localparam logic signed [HOP_W-1:0] TOP = HOP_W'(HOP_AMP);
      localparam logic signed [HOP_W-1:0] BOT = -TOP;
      localparam logic signed [HOP_W-1:0] ONE = HOP_W'(1);
      hop_dir_e dir_q;
      logic signed [HOP_W-1:0] off_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          off_q <= '0;
          dir_q <= HOP_RISE;
        end else if (step) begin
          if (dir_q == HOP_RISE) begin
            if (off_q == TOP) begin
              off_q <= off_q - ONE;
              dir_q <= HOP_FALL;
            end else begin
              off_q <= off_q + ONE;
            end
          end else begin
            if (off_q == BOT) begin
              off_q <= off_q + ONE;
              dir_q <= HOP_RISE;
            end else begin
              off_q <= off_q - ONE;
            end
          end
        end
      end
      assign offset = off_q;
    end
  endgenerate
endmodule

// File: rtl/pwm_period_calc.sv
module pwm_period_calc #(
  parameter int FB_W        = 10,
  parameter int PER_W       = 12,
  parameter int HOP_W       = 6,
  parameter int PERIOD_FAST = 769,
  parameter int PERIOD_SLOW = 2083,
  parameter int KNEE_CODE   = 553,
  parameter int FLOOR_CODE  = 461,
  parameter int DUTY_PCT    = 85
) (
  input  logic [FB_W-1:0]         fb_code,
  input  logic signed [HOP_W-1:0] hop_off,
  output logic [PER_W-1:0]        period,
  output logic [PER_W-1:0]        max_on
);
  localparam int SPAN_CODE = KNEE_CODE - FLOOR_CODE;
  localparam int SPAN_PER  = PERIOD_SLOW - PERIOD_FAST;

  int fb_i;
  int per_i;
  int on_i;

  always_comb begin
    fb_i = int'(fb_code);
    if (fb_i >= KNEE_CODE) begin
      per_i = PERIOD_FAST + int'(hop_off);
    end else if (fb_i <= FLOOR_CODE) begin
      per_i = PERIOD_SLOW;
    end else begin
      per_i = PERIOD_FAST + ((KNEE_CODE - fb_i) * SPAN_PER) / SPAN_CODE;
    end
    on_i   = (per_i * DUTY_PCT) / 100;
    period = PER_W'(per_i);
    max_on = PER_W'(on_i);
  end
endmodule

// File: rtl/pwm_freq_sched.sv
module pwm_freq_sched #(
  parameter int FB_W        = 10,
  parameter int PERIOD_FAST = 769,
  parameter int PERIOD_SLOW = 2083,
  parameter int HOP_AMP     = 20,
  parameter int KNEE_CODE   = 553,
  parameter int FLOOR_CODE  = 461,
  parameter int STOP_CODE   = 410,
  parameter int RESUME_CODE = 430,
  parameter int DUTY_PCT    = 85
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FB_W-1:0] fb_code,
  input  logic            cs_trip,
  output logic            gate_on,
  output logic            cycle_start,
  output logic            burst_active
);
  localparam int PER_W = $clog2(PERIOD_SLOW + 1);
  localparam int HOP_W = $clog2(HOP_AMP + 1) + 1;
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic                    burst;
  logic signed [HOP_W-1:0] hop_off;
  logic [PER_W-1:0]        per_new, on_new;
  logic [PER_W-1:0]        cnt_q, per_q, maxon_q, cnt_nxt;
  logic                    gate_q, start_q, boundary;

  pwm_burst_gate #(
    .FB_W(FB_W), .STOP_CODE(STOP_CODE), .RESUME_CODE(RESUME_CODE)
  ) u_burst (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .burst(burst)
  );

  assign boundary = !burst && (cnt_q == '0);

  pwm_hop_gen #(
    .HOP_AMP(HOP_AMP), .HOP_W(HOP_W)
  ) u_hop (
    .clk(clk), .rst_n(rst_n), .step(boundary), .offset(hop_off)
  );

  pwm_period_calc #(
    .FB_W(FB_W), .PER_W(PER_W), .HOP_W(HOP_W),
    .PERIOD_FAST(PERIOD_FAST), .PERIOD_SLOW(PERIOD_SLOW),
    .KNEE_CODE(KNEE_CODE), .FLOOR_CODE(FLOOR_CODE), .DUTY_PCT(DUTY_PCT)
  ) u_calc (
    .fb_code(fb_code), .hop_off(hop_off), .period(per_new), .max_on(on_new)
  );

  always_comb begin
    cnt_nxt = (cnt_q == per_q - ONE) ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= PER_W'(PERIOD_FAST);
      maxon_q <= '0;
      gate_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (burst) begin
      cnt_q   <= '0;
      gate_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (boundary) begin
      per_q   <= per_new;
      maxon_q <= on_new;
      cnt_q   <= ONE;
      gate_q  <= 1'b1;
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      cnt_q   <= cnt_nxt;
      gate_q  <= gate_q && !cs_trip && (cnt_nxt != '0) && (cnt_nxt <= maxon_q);
    end
  end

  assign gate_on      = gate_q;
  assign cycle_start  = start_q;
  assign burst_active = burst;
endmodule

// File: rtl/pwm_sched_checker.sv
module pwm_sched_checker #(
  parameter int FB_W        = 10,
  parameter int PERIOD_SLOW = 2083,
  parameter int STOP_CODE   = 410,
  parameter int RESUME_CODE = 430,
  parameter int DUTY_PCT    = 85
) (
  input logic            clk,
  input logic            rst_n,
  input logic [FB_W-1:0] fb_code,
  input logic            cs_trip,
  input logic            gate_on,
  input logic            cycle_start,
  input logic            burst_active
);
  localparam int RUN_W   = $clog2(PERIOD_SLOW + 1) + 1;
  localparam int MAX_RUN = (PERIOD_SLOW * DUTY_PCT) / 100;

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (gate_on) run_q <= run_q + RUN_W'(1);
    else run_q <= '0;
  end

  assert_duty_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> (run_q < RUN_W'(MAX_RUN)));

  assert_burst_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_active && (fb_code < FB_W'(STOP_CODE))) |=> burst_active);

  assert_burst_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && $past(burst_active)) |-> (!gate_on && !cycle_start));

  assert_burst_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && (fb_code > FB_W'(RESUME_CODE))) |=> !burst_active);

  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fb_code >= FB_W'(STOP_CODE)) && (fb_code <= FB_W'(RESUME_CODE))) |=> $stable(burst_active));

  assert_cs_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && cs_trip) |=> !gate_on);

  assert_rise_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> cycle_start);

  assert_start_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> gate_on);
endmodule

bind pwm_freq_sched pwm_sched_checker #(
  .FB_W(FB_W), .PERIOD_SLOW(PERIOD_SLOW), .STOP_CODE(STOP_CODE),
  .RESUME_CODE(RESUME_CODE), .DUTY_PCT(DUTY_PCT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .cs_trip(cs_trip),
  .gate_on(gate_on), .cycle_start(cycle_start), .burst_active(burst_active)
);

// File: tb/tb_pwm_freq_sched.sv
module tb_pwm_freq_sched;
  localparam int CLK_PERIOD = 20;
  localparam int FAST = 40;
  localparam int SLOW = 100;
  localparam int AMP  = 3;
  localparam int KNEE = 553;
  localparam int FLR  = 461;
  localparam int STOP = 410;
  localparam int RES  = 430;
  localparam int DUTY = 85;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] fb_code = 10'd800;
  logic       cs_trip = 1'b0;
  logic       gate_on, cycle_start, burst_active;

  int checks = 0;
  int errors = 0;
  string req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_freq_sched #(
    .FB_W(10), .PERIOD_FAST(FAST), .PERIOD_SLOW(SLOW), .HOP_AMP(AMP),
    .KNEE_CODE(KNEE), .FLOOR_CODE(FLR), .STOP_CODE(STOP),
    .RESUME_CODE(RES), .DUTY_PCT(DUTY)
  ) dut (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .cs_trip(cs_trip),
    .gate_on(gate_on), .cycle_start(cycle_start), .burst_active(burst_active)
  );

  // Behavioural reference: time elapsed in the current cycle
  int m_burst, m_pos, m_len, m_cap, m_gate, m_start, m_hop, m_up;

  function automatic int ref_len(int fb, int hop);
    if (fb >= KNEE) return FAST + hop;
    if (fb <= FLR) return SLOW;
    return FAST + ((KNEE - fb) * (SLOW - FAST)) / (KNEE - FLR);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_burst = 0; m_pos = 0; m_len = FAST; m_cap = 0;
      m_gate = 0; m_start = 0; m_hop = 0; m_up = 1;
    end else begin
      int fb, nb;
      fb = int'(fb_code);
      nb = m_burst;
      if (m_burst != 0 && fb > RES) nb = 0;
      else if (m_burst == 0 && fb < STOP) nb = 1;
      if (m_burst != 0) begin
        m_pos = 0; m_gate = 0; m_start = 0;
      end else if (m_pos == 0) begin
        m_len = ref_len(fb, m_hop);
        m_cap = (m_len * DUTY) / 100;
        m_pos = 1; m_gate = 1; m_start = 1;
        if (m_up != 0) begin
          if (m_hop == AMP) begin m_hop = AMP - 1; m_up = 0; end
          else m_hop = m_hop + 1;
        end else begin
          if (m_hop == -AMP) begin m_hop = -AMP + 1; m_up = 1; end
          else m_hop = m_hop - 1;
        end
      end else begin
        m_start = 0;
        m_pos = (m_pos + 1) % m_len;
        if (cs_trip || m_pos == 0 || m_pos > m_cap) m_gate = 0;
      end
      m_burst = nb;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(gate_on == m_gate[0], {req, " gate"}, int'(gate_on), m_gate);
      check(cycle_start == m_start[0], {req, " start"}, int'(cycle_start), m_start);
      check(burst_active == m_burst[0], {req, " burst"}, int'(burst_active), m_burst);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Measures one full cycle from a start strobe; optional trip at position trip_at
  task automatic measure(int trip_at, output int len, output int hi);
    len = 0; hi = 0;
    while (cycle_start !== 1'b1) @(negedge clk);
    do begin
      len++;
      if (gate_on) hi++;
      cs_trip = (len == trip_at);
      @(negedge clk);
    end while (cycle_start !== 1'b1);
    cs_trip = 1'b0;
  endtask

  initial begin
    int p1, p2, h1, h2;
    tick(3);
    // R1: reset values
    check(!gate_on && !cycle_start && !burst_active, "R1 reset outputs",
          int'({gate_on, cycle_start, burst_active}), 0);
    rst_n = 1'b1;
    check(!gate_on && !cycle_start, "R1 after release", int'({gate_on, cycle_start}), 0);

    // R2: fixed region with dither
    req = "R2";
    tick(200);
    measure(0, p1, h1);
    check(p1 >= FAST - AMP && p1 <= FAST + AMP, "R2 fixed period range", p1, FAST);

    // R10: triangle dither steps by one per cycle
    req = "R10";
    measure(0, p1, h1);
    measure(0, p2, h2);
    check((p2 - p1 == 1) || (p1 - p2 == 1), "R10 dither step", p2 - p1, 1);
    tick(400);

    // R9: mid-cycle feedback change does not touch current cycle
    req = "R9";
    while (cycle_start !== 1'b1) @(negedge clk);
    p1 = 0;
    do begin
      p1++;
      if (p1 == 4) fb_code = 10'd507;
      @(negedge clk);
    end while (cycle_start !== 1'b1);
    check(p1 >= FAST - AMP && p1 <= FAST + AMP, "R9 cycle kept its period", p1, FAST);

    // R3: linear band, code 507 -> 40 + 46*60/92 = 70
    req = "R3";
    measure(0, p1, h1);
    check(p1 == 70, "R3 linear period", p1, 70);
    check(h1 == 59, "R7 cap at 70 clocks", h1, 59);

    // R4: floor region, code 440 (between resume level and floor)
    req = "R4";
    fb_code = 10'd440;
    measure(0, p1, h1);
    measure(0, p1, h1);
    check(p1 == SLOW, "R4 floor period", p1, SLOW);
    check(h1 == 85, "R7 cap at floor", h1, 85);

    // R8: current-sense trip at tenth clock of the pulse
    req = "R8";
    measure(10, p1, h1);
    check(h1 == 10, "R8 early end", h1, 10);
    check(p1 == SLOW, "R8 period unchanged", p1, SLOW);

    // R5: burst entry
    req = "R5";
    fb_code = 10'd400;
    tick(3);
    check(burst_active && !gate_on, "R5 burst entered", int'({burst_active, gate_on}), 2);
    p2 = 0;
    for (int i = 0; i < 200; i++) begin
      if (cycle_start || gate_on) p2++;
      @(negedge clk);
    end
    check(p2 == 0, "R5 no switching in burst", p2, 0);

    // R6: hysteresis band holds, above resume releases
    req = "R6";
    fb_code = 10'd420;
    tick(50);
    check(burst_active, "R6 held in band", int'(burst_active), 1);
    fb_code = 10'd430;
    tick(10);
    check(burst_active, "R6 held at resume level", int'(burst_active), 1);
    fb_code = 10'd431;
    tick(2);
    check(!burst_active, "R6 released", int'(burst_active), 0);
    measure(0, p1, h1);
    check(p1 == SLOW, "R6 resumed at floor period", p1, SLOW);

    req = "R2";
    fb_code = 10'd900;
    tick(300);
    finish_run();
  end
endmodule